// File: doc/BRIEF.md
# Echo Path Change Convergence Controller

This block decides when an adaptive echo canceller runs its coefficient update in fast convergence and when it runs in normal convergence. It also decides when the canceller must discard its current echo path estimate. It does not detect path changes itself. An external detector raises a one-cycle pulse, and the canceller's filter datapath follows the two outputs of this block: a fast-mode level and a one-cycle clear-estimate pulse.

Three kinds of event start a fast-convergence period:

- leaving reset;
- the end of a bypass request;
- a path change that the detector enable admits.

A 3-bit duration code sets how long the period lasts. It is counted in units of `TICKS_PER_STEP` frame ticks, and a code of zero keeps fast mode until the next such event. Bypass has priority over everything else: it pins the block in fast mode, freezes the period counter, and on release starts a new period. Every pin is a plain control or status level or pulse. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `conv_ctrl`

## Requirements
- R1: While reset is asserted, `fast_o` is 1 and `clr_est_o` is 0. On the first clock edge after reset is released, a fast period is loaded from `dur_code_i`.
- R2: When `det_en_i` is 0, a pulse on `pc_pulse_i` changes neither output. If the block is in normal mode, it stays there.
- R3: When `det_en_i` is 1, `bypass_i` is 0 and `pc_pulse_i` is 1 at a clock edge, `fast_o` is 1 after that edge and a new period is loaded.
- R4: `clr_est_o` is 1 for exactly the one cycle after the edge that loads the period for an admitted path change, and only if `clr_en_i` was 1 at that edge. It is 0 otherwise.
- R5: A nonzero code N gives a fast period of exactly N × `TICKS_PER_STEP` ticks. `fast_o` falls after the edge that samples the last of those ticks. Ticks in the loading cycle are not counted.
- R6: `clr_en_i` has no effect while `det_en_i` is 0, so `clr_est_o` stays 0.
- R7: A code of 0 at a load keeps `fast_o` at 1 for any number of ticks, until the next load.
- R8: A path change admitted during a fast period reloads the counter from the code present at that edge.
- R9: While `bypass_i` is 1, `fast_o` is 1 one cycle later. Ticks do not advance the period, and path-change pulses are not admitted (`clr_est_o` stays 0).
- R10: At the edge where `bypass_i` is first sampled 0 after being 1, a full new period is loaded from the current code.
- R11: A change of `dur_code_i` during a running period has no effect until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bypass_i | input | 1 | Bypass request level |
| tick_i | input | 1 | Frame tick, one cycle per frame |
| pc_pulse_i | input | 1 | Path-change detection pulse |
| det_en_i | input | 1 | Admit path-change pulses |
| clr_en_i | input | 1 | Clear the estimate on an admitted path change |
| dur_code_i | input | CODE_W | Fast-period duration code; 0 means endless |
| fast_o | output | 1 | 1 = fast convergence, 0 = normal |
| clr_est_o | output | 1 | One-cycle request to clear the echo path estimate |

## Verification
The bench builds the block with `CODE_W` = 3 and `TICKS_PER_STEP` = 4. With those values every period is at most 28 ticks, so all seven nonzero codes can be swept with both settings of the clear enable. The bench checks the output after every single tick, and a period that ends one tick early or one tick late is reported. The small unit also keeps the retrigger, mid-period code change, endless-code and bypass-release cases short enough that each one is checked tick by tick against an expected tick count worked out from the code.

// File: rtl/conv_pkg.sv
package conv_pkg;

  // Source of a period load, kept for readability of the trigger logic.
  typedef enum logic [1:0] {
    LOAD_NONE = 2'd0,
    LOAD_INIT = 2'd1,
    LOAD_BYP  = 2'd2,
    LOAD_PATH = 2'd3
  } load_src_e;

  function automatic int unsigned period_max(int unsigned code_w, int unsigned unit);
    return ((1 << code_w) - 1) * unit;
  endfunction

endpackage

// File: rtl/conv_trig.sv
module conv_trig
  import conv_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bypass_i,
  input  logic      pc_pulse_i,
  input  logic      det_en_i,
  input  logic      clr_en_i,
  output logic      load_o,
  output load_src_e src_o,
  output logic      clr_o
);

  logic init_pend_q;
  logic byp_q;
  logic clr_q;
  logic path_ok;

  // A path change counts only when the detector is on and bypass is not active.
  assign path_ok = pc_pulse_i & det_en_i & ~bypass_i;

  always_comb begin
    src_o = LOAD_NONE;
    if (!bypass_i) begin
      if (path_ok)          src_o = LOAD_PATH;
      else if (byp_q)       src_o = LOAD_BYP;
      else if (init_pend_q) src_o = LOAD_INIT;
    end
  end

  assign load_o = (src_o != LOAD_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_pend_q <= 1'b1;
      byp_q       <= 1'b0;
      clr_q       <= 1'b0;
    end else begin
      init_pend_q <= 1'b0;
      byp_q       <= bypass_i;
      clr_q       <= path_ok & clr_en_i;
    end
  end

  assign clr_o = clr_q;

  // R6: with the detector off, no clear request follows
  a_r6_no_clr_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en_i |=> !clr_o);

  // R4: a clear request is always preceded by an enabled path-change pulse
  a_r4_clr_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    clr_o |-> $past(pc_pulse_i && clr_en_i && !bypass_i));

  // R9: nothing loads while bypass is held
  a_r9_no_load_in_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_i |-> !load_o);

endmodule

// File: rtl/conv_timer.sv
module conv_timer
  import conv_pkg::*;
#(
  parameter int unsigned CODE_W = 3,
  parameter int unsigned UNIT   = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_i,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              tick_i,
  output logic              fast_o
);

  localparam int unsigned MAX_LOAD = period_max(CODE_W, UNIT);
  localparam int unsigned CNT_W    = $clog2(MAX_LOAD + 1);

  logic [CNT_W-1:0] count_q;
  logic             endless_q;
  logic             fast_q;
  logic [CNT_W-1:0] load_val;

  assign load_val = CNT_W'(code_i) * CNT_W'(UNIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q   <= '0;
      endless_q <= 1'b1;
      fast_q    <= 1'b1;
    end else if (hold_i) begin
      fast_q <= 1'b1;
    end else if (load_i) begin
      count_q   <= load_val;
      endless_q <= (code_i == '0);
      fast_q    <= 1'b1;
    end else if (fast_q && !endless_q && tick_i && count_q != '0) begin
      count_q <= count_q - 1'b1;
      if (count_q == CNT_W'(1)) fast_q <= 1'b0;
    end
  end

  assign fast_o = fast_q;

  // R9: hold pins fast mode
  a_r9_hold_forces_fast: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> fast_o);

  // R9: counter frozen across consecutive hold cycles
  a_r9_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (count_q == $past(count_q)));

  // R5: leaving fast mode needs a tick on the last count
  a_r5_drop_on_last_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fast_o) |-> ($past(tick_i) && $past(count_q) == CNT_W'(1)));

  // R7: endless period never ends without a new load
  a_r7_endless_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (endless_q && fast_o && !load_i) |=> fast_o);

endmodule

// File: rtl/conv_ctrl.sv
module conv_ctrl
  import conv_pkg::*;
#(
  parameter int unsigned CODE_W         = 3,
  parameter int unsigned TICKS_PER_STEP = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bypass_i,
  input  logic              tick_i,
  input  logic              pc_pulse_i,
  input  logic              det_en_i,
  input  logic              clr_en_i,
  input  logic [CODE_W-1:0] dur_code_i,
  output logic              fast_o,
  output logic              clr_est_o
);

  logic      load;
  load_src_e load_src;

  conv_trig u_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .bypass_i   (bypass_i),
    .pc_pulse_i (pc_pulse_i),
    .det_en_i   (det_en_i),
    .clr_en_i   (clr_en_i),
    .load_o     (load),
    .src_o      (load_src),
    .clr_o      (clr_est_o)
  );

  conv_timer #(
    .CODE_W (CODE_W),
    .UNIT   (TICKS_PER_STEP)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold_i (bypass_i),
    .load_i (load),
    .code_i (dur_code_i),
    .tick_i (tick_i),
    .fast_o (fast_o)
  );

  // R4: a clear request coincides with a freshly loaded fast period
  a_r4_clr_with_fast: assert property (@(posedge clk) disable iff (!rst_n)
    clr_est_o |-> fast_o);

  // R3: an admitted path change always lands in fast mode
  a_r3_path_gives_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (load_src == LOAD_PATH) |=> fast_o);

endmodule

// File: tb/test_conv_ctrl.sv
`timescale 1ns/1ps
module test_conv_ctrl;

  localparam int CW = 3;
  localparam int U  = 4;

  logic clk = 1'b0;
  logic rst_n, bypass, tick, pc, det_en, clr_en;
  logic [CW-1:0] code;
  logic fast, clr;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  conv_ctrl #(.CODE_W(CW), .TICKS_PER_STEP(U)) i_conv_ctrl (
    .clk(clk), .rst_n(rst_n), .bypass_i(bypass), .tick_i(tick),
    .pc_pulse_i(pc), .det_en_i(det_en), .clr_en_i(clr_en),
    .dur_code_i(code), .fast_o(fast), .clr_est_o(clr)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // Apply `limit` ticks; fast expected high while fewer than `total` seen (0 = endless)
  task automatic run_ticks(int total, int limit, string req);
    for (int k = 1; k <= limit; k++) begin
      tick = 1'b1;
      cyc();
      tick = 1'b0;
      check(req, fast, (total == 0) ? 1'b1 : logic'(k < total));
    end
  endtask

  task automatic pulse_pc();
    pc = 1'b1;
    cyc();
    pc = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; bypass = 1'b0; tick = 1'b0; pc = 1'b0;
    det_en = 1'b0; clr_en = 1'b0; code = 3'd2;
    cyc(); cyc();
    check("R1 fast in reset", fast, 1'b1);
    check("R1 clr in reset", clr, 1'b0);
    rst_n = 1'b1;
    cyc();
    check("R1 fast after release", fast, 1'b1);
    run_ticks(2 * U, 2 * U + 2, "R1 initial period");

    // R3 R4 R5 sweep: all nonzero codes, both clear settings
    det_en = 1'b1;
    for (int c = 1; c < 8; c++) begin
      for (int ce = 0; ce < 2; ce++) begin
        code = CW'(c);
        clr_en = logic'(ce);
        check("R3 normal before pulse", fast, 1'b0);
        pulse_pc();
        check("R3 fast on path change", fast, 1'b1);
        check("R4 clr follows enable", clr, logic'(ce));
        cyc();
        check("R4 clr single cycle", clr, 1'b0);
        run_ticks(c * U, c * U + 2, "R5 period length");
      end
    end

    // R2 R6: detector disabled
    det_en = 1'b0; clr_en = 1'b1;
    pulse_pc();
    check("R2 fast unchanged", fast, 1'b0);
    check("R6 no clr when disabled", clr, 1'b0);
    cyc();
    check("R2 still normal", fast, 1'b0);
    check("R6 still no clr", clr, 1'b0);

    // R7: endless code
    det_en = 1'b1; clr_en = 1'b0; code = 3'd0;
    pulse_pc();
    run_ticks(0, 50, "R7 endless");
    code = 3'd1;
    run_ticks(0, 10, "R11 endless after code change");
    pulse_pc();
    run_ticks(U, U + 2, "R7 leaves on next load");

    // R8: retrigger reloads from current code
    code = 3'd3;
    pulse_pc();
    run_ticks(3 * U, 2 * U, "R8 first period part");
    code = 3'd1;
    pulse_pc();
    run_ticks(U, U + 2, "R8 reload length");

    // R11: code change mid-period
    code = 3'd2;
    pulse_pc();
    run_ticks(2 * U, 3, "R11 before change");
    code = 3'd5;
    run_ticks(2 * U - 3, 2 * U, "R11 after change");

    // R9 R10: bypass during a period
    code = 3'd2; clr_en = 1'b1;
    pulse_pc();
    cyc();
    run_ticks(2 * U, 3, "R9 before bypass");
    bypass = 1'b1;
    cyc();
    check("R9 fast in bypass", fast, 1'b1);
    pulse_pc();
    check("R9 no clr in bypass", clr, 1'b0);
    run_ticks(0, 20, "R9 ticks frozen");
    bypass = 1'b0;
    cyc();
    check("R10 fast on release", fast, 1'b1);
    run_ticks(2 * U, 2 * U + 2, "R10 fresh period");

    // R9 R10: bypass from normal mode
    bypass = 1'b1;
    cyc();
    check("R9 bypass from normal", fast, 1'b1);
    bypass = 1'b0;
    code = 3'd1;
    cyc();
    run_ticks(U, U + 2, "R10 period after short bypass");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule